// File: doc/BRIEF.md
# Page Table Address Translator

This block maps logical addresses onto physical addresses through a small page table kept entirely in flip-flops. Each request address is cut into a page index, taken from the high bits, and a byte offset, taken from the low bits. The page index selects one table entry. That entry holds a frame number and a valid flag. A valid entry produces a physical address: the frame number sits above the unchanged offset. An entry whose flag is clear raises a fault instead.

Privileged software fills the table through a write port that carries an index, a frame number and a valid flag. Requests arrive with a strobe. Each result appears one clock later with its own strobe. Because protection is decided page by page, an address past the last byte a program uses is still translated when its page is valid. With the default settings the address is 14 bits wide, pages are 2048 bytes, and the table has 8 entries.

Top module: `page_xlate`

## Requirements
- R1: The page index is bits [ADDR_W-1:OFF_W] of the request address and the offset is bits [OFF_W-1:0], where OFF_W = log2(PAGE_BYTES) and PAGE_BYTES is a power of two (11 bits of offset and 3 bits of page index by default).
- R2: A request that selects a valid entry returns rsp_paddr = {frame, offset} with rsp_fault low, on the clock edge after the request is accepted.
- R3: A request that selects an invalid entry returns rsp_fault high and rsp_paddr equal to zero, on the clock edge after the request.
- R4: Reset clears every valid flag, so any request made after reset and before a table write faults.
- R5: A table write changes its entry from the next cycle on. A request in the same cycle as a write to its entry is translated with the old contents.
- R6: rsp_valid is high exactly one cycle after each cycle in which req_valid is high. While rsp_valid is low, rsp_fault and rsp_paddr are zero.
- R7: An address inside a valid page is translated without a fault even when it lies past the program's last used byte (for example 10468 to 12287 in page 5 by default).
- R8: Writing an entry with the valid flag clear makes later requests to that page fault.
- R9: A table write changes only the entry it indexes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Table write strobe |
| wr_idx | input | ADDR_W-OFF_W | Index of the entry to write |
| wr_frame | input | FRAME_W | Frame number to store |
| wr_valid | input | 1 | Valid flag to store |
| req_valid | input | 1 | Translation request strobe |
| req_addr | input | ADDR_W | Logical address to translate |
| rsp_valid | output | 1 | Result strobe, one cycle after the request |
| rsp_paddr | output | FRAME_W+OFF_W | Physical address, zero on a fault |
| rsp_fault | output | 1 | Request selected an invalid page |

## Verification
The bench uses the default parameters: a 14-bit address, 2048-byte pages and 5-bit frames. These give 8 entries and a 16-bit physical address. With this size the bench can visit every entry, both the reset state and every programmed state. It can reach the tail of page 5 that lies beyond the program's last used byte, and the invalid pages 6 and 7. It also covers a write and a request to the same entry in one cycle, and two requests on back-to-back cycles.

// File: rtl/page_xlate_pkg.sv
// Package page_xlate_pkg
// Holds the default sizes shared by the translator and its bench, plus a
// helper that derives the offset width from the page size.
// Assumes the page size is a power of two.
package page_xlate_pkg;
    localparam int unsigned DEF_ADDR_W     = 14;
    localparam int unsigned DEF_PAGE_BYTES = 2048;
    localparam int unsigned DEF_FRAME_W    = 5;

    // Number of offset bits for a page of the given byte count.
    function automatic int unsigned offset_bits(input int unsigned bytes);
        return $clog2(bytes);
    endfunction
endpackage

// File: rtl/pt_addr_split.sv
// Module pt_addr_split
// Cuts a logical address into its page index (high bits) and its byte
// offset (low bits). Purely combinational.
// Assumes ADDR_W > OFF_W.
module pt_addr_split #(
    parameter int unsigned ADDR_W = 14,
    parameter int unsigned OFF_W  = 11,
    localparam int unsigned PN_W  = ADDR_W - OFF_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [PN_W-1:0]   page,
    output logic [OFF_W-1:0]  offset
);
    // Field extraction.
    always_comb begin
        page   = addr[ADDR_W-1:OFF_W];
        offset = addr[OFF_W-1:0];
    end
endmodule

// File: rtl/pt_table.sv
// Module pt_table
// Page table held in registers: one frame number and one valid flag per
// entry. There is one synchronous write port and one combinational read
// port. A read in the same cycle as a write returns the old contents.
// Reset clears only the valid flags.
module pt_table #(
    parameter int unsigned ENTRIES = 8,
    parameter int unsigned FRAME_W = 5,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [FRAME_W-1:0] wr_frame,
    input  logic               wr_valid,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [FRAME_W-1:0] rd_frame,
    output logic               rd_valid
);
    logic [ENTRIES-1:0]              vld_q;
    logic [ENTRIES-1:0][FRAME_W-1:0] frm_q;
    logic [ENTRIES-1:0]              wsel;

    // Per-entry write select decode.
    for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_sel
        assign wsel[gi] = wr_en && (wr_idx == IDX_W'(gi));
    end

    // Valid flags: cleared by reset, loaded on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (wsel[i]) vld_q[i] <= wr_valid;
            end
        end
    end

    // Frame numbers: loaded on a write, no reset needed.
    always_ff @(posedge clk) begin
        for (int i = 0; i < ENTRIES; i++) begin
            if (wsel[i]) frm_q[i] <= wr_frame;
        end
    end

    // Read port.
    always_comb begin
        rd_frame = frm_q[rd_idx];
        rd_valid = vld_q[rd_idx];
    end
endmodule

// File: rtl/pt_resp_reg.sv
// Module pt_resp_reg
// Registers the translation result. It joins the frame number to the
// offset on a hit, and gives a zero address with a fault on an invalid
// entry. All outputs are zero in cycles with no request.
module pt_resp_reg #(
    parameter int unsigned FRAME_W = 5,
    parameter int unsigned OFF_W   = 11,
    localparam int unsigned PADDR_W = FRAME_W + OFF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               hit,
    input  logic [FRAME_W-1:0] frame,
    input  logic [OFF_W-1:0]   offset,
    output logic               rsp_valid,
    output logic [PADDR_W-1:0] rsp_paddr,
    output logic               rsp_fault
);
    // Result register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_paddr <= '0;
            rsp_fault <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            rsp_fault <= req_valid && !hit;
            rsp_paddr <= (req_valid && hit) ? {frame, offset} : '0;
        end
    end
endmodule

// File: rtl/page_xlate.sv
// Module page_xlate
// Translates logical addresses to physical addresses through a page table
// held in registers. The result has a latency of one cycle. Table writes
// take effect on the following cycle.
// Assumes PAGE_BYTES is a power of two and smaller than 2**ADDR_W.
module page_xlate
    import page_xlate_pkg::*;
#(
    parameter int unsigned ADDR_W     = DEF_ADDR_W,
    parameter int unsigned PAGE_BYTES = DEF_PAGE_BYTES,
    parameter int unsigned FRAME_W    = DEF_FRAME_W,
    localparam int unsigned OFF_W     = offset_bits(PAGE_BYTES),
    localparam int unsigned PN_W      = ADDR_W - OFF_W,
    localparam int unsigned ENTRIES   = 1 << PN_W,
    localparam int unsigned PADDR_W   = FRAME_W + OFF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [PN_W-1:0]    wr_idx,
    input  logic [FRAME_W-1:0] wr_frame,
    input  logic               wr_valid,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  req_addr,
    output logic               rsp_valid,
    output logic [PADDR_W-1:0] rsp_paddr,
    output logic               rsp_fault
);
    logic [PN_W-1:0]    page;
    logic [OFF_W-1:0]   offset;
    logic [FRAME_W-1:0] frame;
    logic               hit;

    pt_addr_split #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_split (
        .addr   (req_addr),
        .page   (page),
        .offset (offset)
    );

    pt_table #(.ENTRIES(ENTRIES), .FRAME_W(FRAME_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_frame (wr_frame),
        .wr_valid (wr_valid),
        .rd_idx   (page),
        .rd_frame (frame),
        .rd_valid (hit)
    );

    pt_resp_reg #(.FRAME_W(FRAME_W), .OFF_W(OFF_W)) u_resp (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .hit       (hit),
        .frame     (frame),
        .offset    (offset),
        .rsp_valid (rsp_valid),
        .rsp_paddr (rsp_paddr),
        .rsp_fault (rsp_fault)
    );
endmodule

// File: rtl/page_xlate_chk.sv
// Module page_xlate_chk
// Port-level protocol checks for page_xlate, attached with bind.
module page_xlate_chk #(
    parameter int unsigned ADDR_W  = 14,
    parameter int unsigned OFF_W   = 11,
    parameter int unsigned PADDR_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic [ADDR_W-1:0]  req_addr,
    input logic               rsp_valid,
    input logic [PADDR_W-1:0] rsp_paddr,
    input logic               rsp_fault
);
    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R6
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_fault && rsp_paddr == '0)); // R6
    AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_valid && rsp_paddr == '0)); // R3
    AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_fault || rsp_paddr[OFF_W-1:0] == $past(req_addr[OFF_W-1:0]))); // R2
endmodule

bind page_xlate page_xlate_chk #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W),
    .PADDR_W(PADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .rsp_valid (rsp_valid),
    .rsp_paddr (rsp_paddr),
    .rsp_fault (rsp_fault)
);

// File: tb/page_xlate_tb.sv
// Directed bench for page_xlate with default parameters.
module page_xlate_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W  = 14;
    localparam int PAGE    = 2048;
    localparam int OFF_W   = 11;
    localparam int PN_W    = 3;
    localparam int FRAME_W = 5;
    localparam int PADDR_W = 16;
    localparam int ENTRIES = 8;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               wr_en = 1'b0;
    logic [PN_W-1:0]    wr_idx = '0;
    logic [FRAME_W-1:0] wr_frame = '0;
    logic               wr_valid = 1'b0;
    logic               req_valid = 1'b0;
    logic [ADDR_W-1:0]  req_addr = '0;
    logic               rsp_valid;
    logic [PADDR_W-1:0] rsp_paddr;
    logic               rsp_fault;

    int checks = 0;
    int errors = 0;
    int m_frame [ENTRIES];
    bit m_vld   [ENTRIES];

    page_xlate u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_frame(wr_frame), .wr_valid(wr_valid), .req_valid(req_valid),
        .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
        .rsp_fault(rsp_fault)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tbl_write(input int idx, input int frame, input bit v);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = PN_W'(idx); wr_frame = FRAME_W'(frame); wr_valid = v;
        @(negedge clk);
        wr_en = 1'b0;
        m_frame[idx] = frame; m_vld[idx] = v;
    endtask

    // Issue one request and check it against the model.
    task automatic req_check(input int addr, input string tag);
        int pg;
        int exp_pa;
        pg = addr / PAGE;
        exp_pa = m_vld[pg] ? m_frame[pg] * PAGE + addr % PAGE : 0;
        @(negedge clk);
        req_valid = 1'b1; req_addr = ADDR_W'(addr);
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " valid"}, int'(rsp_valid), 1);
        check({tag, " fault"}, int'(rsp_fault), m_vld[pg] ? 0 : 1);
        check({tag, " paddr"}, int'(rsp_paddr), exp_pa);
    endtask

    task automatic t_reset;
        check("R6 reset rsp_valid", int'(rsp_valid), 0);
        check("R6 reset rsp_fault", int'(rsp_fault), 0);
        for (int i = 0; i < ENTRIES; i++) req_check(i * PAGE + 7, "R4 post-reset fault");
    endtask

    task automatic t_program;
        for (int i = 0; i < 6; i++) tbl_write(i, i * 3 + 2, 1'b1);
        tbl_write(6, 31, 1'b0);
        tbl_write(7, 30, 1'b0);
    endtask

    task automatic t_split_and_hit;
        req_check(0, "R2 page0 start");
        req_check(2047, "R1 page0 last offset");
        req_check(4097, "R1 page2 offset1");
        req_check(2048 * 3 + 1000, "R2 page3");
    endtask

    task automatic t_tail;
        req_check(10468, "R7 tail start");
        req_check(12287, "R7 tail end");
    endtask

    task automatic t_invalid;
        req_check(12288, "R3 page6");
        req_check(16383, "R3 page7 top");
    endtask

    task automatic t_same_cycle;
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 3'd1; wr_frame = 5'd30; wr_valid = 1'b1;
        req_valid = 1'b1; req_addr = 14'(2048 + 5);
        @(negedge clk);
        wr_en = 1'b0; req_valid = 1'b0;
        check("R5 same-cycle old frame", int'(rsp_paddr), m_frame[1] * PAGE + 5);
        m_frame[1] = 30;
        req_check(2048 + 5, "R5 new frame next cycle");
    endtask

    task automatic t_clear_and_isolate;
        tbl_write(1, 9, 1'b0);
        req_check(2048 + 100, "R8 cleared entry faults");
        req_check(4096 + 100, "R9 neighbour page2 intact");
        req_check(0, "R9 neighbour page0 intact");
    endtask

    task automatic t_back_to_back;
        @(negedge clk);
        req_valid = 1'b1; req_addr = 14'(4096 + 3);
        @(negedge clk);
        req_addr = 14'(12288 + 3);
        check("R2 b2b first paddr", int'(rsp_paddr), m_frame[2] * PAGE + 3);
        @(negedge clk);
        req_valid = 1'b0;
        check("R3 b2b second fault", int'(rsp_fault), 1);
        check("R3 b2b second paddr", int'(rsp_paddr), 0);
        @(negedge clk);
        check("R6 idle valid", int'(rsp_valid), 0);
        check("R6 idle paddr", int'(rsp_paddr), 0);
    endtask

    bit done = 1'b0;

    initial begin
        for (int i = 0; i < ENTRIES; i++) begin m_frame[i] = 0; m_vld[i] = 1'b0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_program();
        t_split_and_hit();
        t_tail();
        t_invalid();
        t_same_cycle();
        t_clear_and_isolate();
        t_back_to_back();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule